// File: doc/BRIEF.md
# Indirect Memory Addressing Unit

This block keeps three separate 12-bit pointers into data memory and gives the core a set of virtual register addresses through which it reaches memory indirectly. Each pointer has its own window of eight register addresses. Five of them are virtual access ports, one for each addressing mode: plain, post-increment, post-decrement, pre-increment and signed offset by the working register. Two of them hold the pointer's low and high bytes, and the last one is unused. A read or write of a virtual port forms an effective address, forwards the access to a byte-wide data-memory port, and applies the pointer update that the mode calls for at the same clock edge.

The core drives a register address together with a read or write strobe. Read data comes back in the same cycle. A pointer update, or a write to a pointer byte, takes effect at the next rising clock edge. Addresses outside the 24-address window are not handled by this block: they return 0 and cause no memory access.

Top module: `indirect_addr_unit`

## Requirements
- R1: After reset, reading the high-byte register of every pointer returns 0x00.
- R2: The register at window offset 5 (the low byte) stores and returns all 8 bits. The register at offset 6 (the high byte) stores only bits 3:0, and bits 7:4 always read as 0.
- R3: Offset 0 (plain) uses the pointer as the memory address and leaves the pointer unchanged.
- R4: Offset 1 (post-increment) uses the current pointer as the address and then adds 1. The carry propagates from the low byte into the high byte, and 0xFFF wraps to 0x000.
- R5: Offset 2 (post-decrement) uses the current pointer as the address and then subtracts 1. The borrow propagates across the bytes, and 0x000 wraps to 0xFFF.
- R6: Offset 3 (pre-increment) uses pointer+1 (mod 4096) as the address, and the pointer takes that same value.
- R7: Offset 4 (working-register offset) uses pointer + sign-extended 8-bit working register (mod 4096) as the address and leaves the pointer unchanged.
- R8: A write through a virtual port asserts mem_wr with cpu_wdata at the effective address. A read returns mem_rdata in the same cycle with mem_rd asserted.
- R9: An access to one pointer's window never changes either of the other two pointers.
- R10: If the effective address equals any virtual port address (offsets 0–4 of any pointer window, base 0xFE0 with pointer k at 0xFE0+8k), neither memory strobe is asserted and a read returns 0. The pointer update of the mode still occurs.
- R11: An access outside the window, or to offset 7, asserts no memory strobe, returns 0 and changes no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_addr | input | 12 | Register-file address from the core |
| cpu_rd | input | 1 | Read strobe for the current cycle |
| cpu_wr | input | 1 | Write strobe for the current cycle |
| cpu_wdata | input | 8 | Write data from the core |
| cpu_rdata | output | 8 | Read data to the core (combinational) |
| wreg | input | 8 | Working register value, used as a signed offset |
| mem_addr | output | 12 | Effective data-memory address |
| mem_rd | output | 1 | Data-memory read strobe |
| mem_wr | output | 1 | Data-memory write strobe |
| mem_wdata | output | 8 | Data-memory write data |
| mem_rdata | input | 8 | Data-memory read data |

## Verification
The bench targets the byte boundaries of the pointer arithmetic: 0x0FF to 0x100, 0x100 to 0x0FF, and both directions of the 4096 wrap. A design that did not carry between the bytes would fall back to the start of the same 256-byte page. The working-register offset is tried with positive, negative and most-negative values, which exposes zero-extension instead of sign extension, and pre-increment is checked for using the new value rather than the old one as the address. Accesses whose effective address lands on a virtual port must stay silent while still updating the pointer; a design that forwarded them would corrupt memory, and one that skipped the update would leave the pointer stuck.

// File: rtl/iau_pkg.sv
package iau_pkg;

  // Position of each register inside one pointer's window.
  typedef enum logic [2:0] {
    OFF_PLAIN   = 3'd0,
    OFF_POSTINC = 3'd1,
    OFF_POSTDEC = 3'd2,
    OFF_PREINC  = 3'd3,
    OFF_PLUSW   = 3'd4,
    OFF_LOW     = 3'd5,
    OFF_HIGH    = 3'd6,
    OFF_SPARE   = 3'd7
  } slot_off_e;

  localparam int SLOT_SPAN = 8;
  localparam int SLOT_SH   = 3;

endpackage

// File: rtl/iau_rst_sync.sv
module iau_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/iau_decode.sv
module iau_decode
  import iau_pkg::*;
#(
  parameter int                 NUM_PTR = 3,
  parameter int                 PTR_W   = 12,
  parameter logic [PTR_W-1:0]   BASE    = 12'hFE0,
  localparam int                IDX_W   = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic [PTR_W-1:0] addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output slot_off_e        off
);

  localparam int WIN_SIZE = NUM_PTR * SLOT_SPAN;

  logic [PTR_W-1:0] rel;

  always_comb begin
    rel = addr - BASE;
    hit = (addr >= BASE) && (int'(rel) < WIN_SIZE);
    idx = IDX_W'(rel >> SLOT_SH);
    off = slot_off_e'(rel[SLOT_SH-1:0]);
  end

endmodule

// File: rtl/iau_ptr_slot.sv
module iau_ptr_slot
  import iau_pkg::*;
#(
  parameter int PTR_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  slot_off_e         off,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] wreg,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [PTR_W-1:0]  ea
);

  localparam int HI_W = PTR_W - DATA_W;

  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [PTR_W-1:0]  ptr_nxt;
  logic [PTR_W-1:0]  ptr_inc;
  logic [PTR_W-1:0]  ptr_dec;
  logic [PTR_W-1:0]  wreg_sx;
  logic              lo_en;
  logic              hi_en;
  logic              step_en;

  assign ptr_q   = {hi_q, lo_q};
  assign ptr_inc = ptr_q + PTR_W'(1);
  assign ptr_dec = ptr_q - PTR_W'(1);
  assign wreg_sx = {{HI_W{wreg[DATA_W-1]}}, wreg};

  // Effective address for each mode
  always_comb begin
    unique case (off)
      OFF_PREINC: ea = ptr_inc;
      OFF_PLUSW:  ea = ptr_q + wreg_sx;
      default:    ea = ptr_q;
    endcase
  end

  // Next pointer value and byte enables
  always_comb begin
    ptr_nxt = ptr_q;
    step_en = 1'b0;
    unique case (off)
      OFF_POSTINC, OFF_PREINC: begin
        ptr_nxt = ptr_inc;
        step_en = sel;
      end
      OFF_POSTDEC: begin
        ptr_nxt = ptr_dec;
        step_en = sel;
      end
      OFF_LOW:  ptr_nxt = {hi_q, wdata};
      OFF_HIGH: ptr_nxt = {wdata[HI_W-1:0], lo_q};
      default:  ptr_nxt = ptr_q;
    endcase
    lo_en = step_en || (sel && wr && (off == OFF_LOW));
    hi_en = step_en || (sel && wr && (off == OFF_HIGH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= ptr_nxt[PTR_W-1:DATA_W];
    end
  end

  // Low byte carries no reset: its value is undefined until written.
  always_ff @(posedge clk) begin
    if (lo_en) begin
      lo_q <= ptr_nxt[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/indirect_addr_unit.sv
module indirect_addr_unit
  import iau_pkg::*;
#(
  parameter int               NUM_PTR = 3,
  parameter int               PTR_W   = 12,
  parameter int               DATA_W  = 8,
  parameter logic [PTR_W-1:0] BASE    = 12'hFE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] wreg,
  output logic [PTR_W-1:0]  mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int IDX_W    = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;
  localparam int WIN_SIZE = NUM_PTR * SLOT_SPAN;
  localparam int HI_W     = PTR_W - DATA_W;

  logic                          rst_sync_n;
  logic                          acc;
  logic                          win_hit;
  logic [IDX_W-1:0]              win_idx;
  slot_off_e                     win_off;
  logic                          virt;
  logic                          self_hit;
  logic [PTR_W-1:0]              ea_rel;
  logic [PTR_W-1:0]              sel_ea;
  logic [PTR_W-1:0]              sel_ptr;
  logic [NUM_PTR-1:0][PTR_W-1:0] ptr_all;
  logic [NUM_PTR-1:0][PTR_W-1:0] ea_all;

  iau_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  iau_decode #(
    .NUM_PTR (NUM_PTR),
    .PTR_W   (PTR_W),
    .BASE    (BASE)
  ) u_dec (
    .addr (cpu_addr),
    .hit  (win_hit),
    .idx  (win_idx),
    .off  (win_off)
  );

  assign acc  = cpu_rd || cpu_wr;
  assign virt = win_hit && (win_off <= OFF_PLUSW);

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_slot
    logic slot_sel;
    assign slot_sel = acc && win_hit && (win_idx == IDX_W'(g));

    iau_ptr_slot #(
      .PTR_W  (PTR_W),
      .DATA_W (DATA_W)
    ) u_slot (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .sel   (slot_sel),
      .wr    (cpu_wr),
      .off   (win_off),
      .wdata (cpu_wdata),
      .wreg  (wreg),
      .ptr_q (ptr_all[g]),
      .ea    (ea_all[g])
    );
  end

  // Select the addressed slot's pointer and effective address
  always_comb begin
    sel_ea  = '0;
    sel_ptr = '0;
    for (int k = 0; k < NUM_PTR; k++) begin
      if (win_idx == IDX_W'(k)) begin
        sel_ea  = ea_all[k];
        sel_ptr = ptr_all[k];
      end
    end
  end

  // Effective address pointing back into the virtual ports
  always_comb begin
    ea_rel   = sel_ea - BASE;
    self_hit = (sel_ea >= BASE) && (int'(ea_rel) < WIN_SIZE) &&
               (ea_rel[SLOT_SH-1:0] <= 3'(OFF_PLUSW));
  end

  assign mem_addr  = sel_ea;
  assign mem_wdata = cpu_wdata;
  assign mem_rd    = cpu_rd && virt && !self_hit;
  assign mem_wr    = cpu_wr && virt && !self_hit;

  always_comb begin
    cpu_rdata = '0;
    if (win_hit) begin
      unique case (win_off)
        OFF_PLAIN, OFF_POSTINC, OFF_POSTDEC, OFF_PREINC, OFF_PLUSW:
          cpu_rdata = self_hit ? '0 : mem_rdata;
        OFF_LOW:  cpu_rdata = sel_ptr[DATA_W-1:0];
        OFF_HIGH: cpu_rdata = {{(DATA_W-HI_W){1'b0}}, sel_ptr[PTR_W-1:DATA_W]};
        default:  cpu_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/iau_checker.sv
module iau_checker #(
  parameter int NUM_PTR = 3,
  parameter int PTR_W   = 12,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cpu_rd,
  input logic                          cpu_wr,
  input logic [DATA_W-1:0]             cpu_rdata,
  input logic                          mem_rd,
  input logic                          mem_wr,
  input logic [PTR_W-1:0]              mem_addr,
  input logic                          win_hit,
  input logic [IDX_W-1:0]              win_idx,
  input logic [2:0]                    win_off,
  input logic                          self_hit,
  input logic [NUM_PTR-1:0][PTR_W-1:0] ptr_all
);

  logic acc;
  assign acc = cpu_rd || cpu_wr;

  // R3
  plain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && win_hit && win_off == 3'd0) |=>
      ptr_all[$past(win_idx)] == $past(ptr_all[win_idx]));

  // R4
  postinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && win_hit && win_off == 3'd1) |=>
      ptr_all[$past(win_idx)] == PTR_W'($past(ptr_all[win_idx]) + PTR_W'(1)));

  // R5
  postdec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && win_hit && win_off == 3'd2) |=>
      ptr_all[$past(win_idx)] == PTR_W'($past(ptr_all[win_idx]) - PTR_W'(1)));

  // R6
  preinc_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && win_hit && win_off == 3'd3) |->
      mem_addr == PTR_W'(ptr_all[win_idx] + PTR_W'(1)));

  // R7
  plusw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && win_hit && win_off == 3'd4) |=>
      ptr_all[$past(win_idx)] == $past(ptr_all[win_idx]));

  // R10
  self_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && win_off <= 3'd4 && self_hit) |->
      (!mem_rd && !mem_wr && cpu_rdata == '0));

  // R11
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_hit || win_off == 3'd7) |->
      (!mem_rd && !mem_wr && cpu_rdata == '0));

  // R2
  hi_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && win_off == 3'd6) |->
      cpu_rdata[DATA_W-1:PTR_W-DATA_W] == '0);

endmodule

bind indirect_addr_unit iau_checker #(
  .NUM_PTR (NUM_PTR),
  .PTR_W   (PTR_W),
  .DATA_W  (DATA_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .cpu_rdata (cpu_rdata),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .win_hit   (win_hit),
  .win_idx   (win_idx),
  .win_off   (3'(win_off)),
  .self_hit  (self_hit),
  .ptr_all   (ptr_all)
);

// File: tb/indirect_addr_unit_bench.sv
module indirect_addr_unit_bench;

  localparam logic [11:0] BASE = 12'hFE0;

  logic        clk;
  logic        rst_n;
  logic [11:0] cpu_addr;
  logic        cpu_rd;
  logic        cpu_wr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic [7:0]  wreg;
  logic [11:0] mem_addr;
  logic        mem_rd;
  logic        mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  logic [7:0]  mem [0:4095];
  int          errors = 0;
  int          checks = 0;
  logic        done = 1'b0;
  logic        s_mrd;
  logic        s_mwr;
  logic [11:0] s_maddr;

  indirect_addr_unit u_indirect_addr_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .wreg      (wreg),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  function automatic logic [7:0] pat(input logic [11:0] a);
    return 8'((a * 7) + 3);
  endfunction

  function automatic logic [11:0] ra(input int k, input int off);
    return BASE + 12'(8 * k + off);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] ad, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = ad; cpu_rd = 1'b1;
    #5;
    d = cpu_rdata; s_mrd = mem_rd; s_mwr = mem_wr; s_maddr = mem_addr;
    @(posedge clk); #1;
    cpu_rd = 1'b0;
  endtask

  task automatic wr(input logic [11:0] ad, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = ad; cpu_wr = 1'b1; cpu_wdata = d;
    #5;
    s_mrd = mem_rd; s_mwr = mem_wr; s_maddr = mem_addr;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic set_ptr(input int k, input logic [11:0] v);
    wr(ra(k, 6), {4'h0, v[11:8]});
    wr(ra(k, 5), v[7:0]);
  endtask

  task automatic get_ptr(input int k, output logic [11:0] v);
    logic [7:0] h;
    logic [7:0] l;
    rd(ra(k, 6), h);
    rd(ra(k, 5), l);
    v = {h[3:0], l};
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int k = 0; k < 3; k++) begin
      rd(ra(k, 6), d);
      chk("R1 high byte after reset", d, 8'h00);
    end
    wr(ra(1, 6), 8'hFF);
    rd(ra(1, 6), d);
    chk("R2 high byte keeps 4 bits", d, 8'h0F);
    wr(ra(1, 5), 8'hA5);
    rd(ra(1, 5), d);
    chk("R2 low byte full width", d, 8'hA5);
  endtask

  task automatic t_plain;
    logic [7:0]  d;
    logic [11:0] p;
    set_ptr(0, 12'h123);
    rd(ra(0, 0), d);
    chk("R3 plain addr", s_maddr, 12'h123);
    chk("R8 read data", d, pat(12'h123));
    chk("R8 mem_rd strobe", s_mrd, 1);
    get_ptr(0, p);
    chk("R3 plain leaves pointer", p, 12'h123);
    wr(ra(0, 0), 8'h5A);
    chk("R8 mem_wr strobe", s_mwr, 1);
    rd(ra(0, 0), d);
    chk("R8 written data read back", d, 8'h5A);
  endtask

  task automatic t_postinc;
    logic [7:0]  d;
    logic [11:0] p;
    set_ptr(1, 12'h0FF);
    rd(ra(1, 1), d);
    chk("R4 postinc addr", s_maddr, 12'h0FF);
    chk("R4 postinc data", d, pat(12'h0FF));
    get_ptr(1, p);
    chk("R4 postinc carry", p, 12'h100);
    set_ptr(1, 12'hFFF);
    rd(ra(1, 1), d);
    get_ptr(1, p);
    chk("R4 postinc wrap", p, 12'h000);
  endtask

  task automatic t_postdec;
    logic [7:0]  d;
    logic [11:0] p;
    set_ptr(2, 12'h100);
    rd(ra(2, 2), d);
    chk("R5 postdec addr", s_maddr, 12'h100);
    get_ptr(2, p);
    chk("R5 postdec borrow", p, 12'h0FF);
    set_ptr(2, 12'h000);
    rd(ra(2, 2), d);
    get_ptr(2, p);
    chk("R5 postdec wrap", p, 12'hFFF);
  endtask

  task automatic t_preinc;
    logic [7:0]  d;
    logic [11:0] p;
    set_ptr(0, 12'h2FF);
    rd(ra(0, 3), d);
    chk("R6 preinc addr", s_maddr, 12'h300);
    chk("R6 preinc data", d, pat(12'h300));
    get_ptr(0, p);
    chk("R6 preinc pointer", p, 12'h300);
    set_ptr(0, 12'hFFF);
    wr(ra(0, 3), 8'hC3);
    chk("R6 preinc wrap addr", s_maddr, 12'h000);
    get_ptr(0, p);
    chk("R6 preinc wrap pointer", p, 12'h000);
    rd(ra(0, 0), d);
    chk("R8 preinc write landed", d, 8'hC3);
  endtask

  task automatic t_plusw;
    logic [7:0]  d;
    logic [11:0] p;
    set_ptr(1, 12'h400);
    wreg = 8'h10;
    rd(ra(1, 4), d);
    chk("R7 positive offset", s_maddr, 12'h410);
    chk("R7 data", d, pat(12'h410));
    wreg = 8'hF0;
    rd(ra(1, 4), d);
    chk("R7 negative offset", s_maddr, 12'h3F0);
    get_ptr(1, p);
    chk("R7 pointer unchanged", p, 12'h400);
    set_ptr(1, 12'h005);
    wreg = 8'h80;
    rd(ra(1, 4), d);
    chk("R7 most negative wrap", s_maddr, 12'hF85);
    wreg = 8'h00;
  endtask

  task automatic t_indep;
    logic [7:0]  d;
    logic [11:0] p;
    set_ptr(0, 12'h010);
    set_ptr(1, 12'h020);
    set_ptr(2, 12'h030);
    rd(ra(1, 1), d);
    rd(ra(1, 1), d);
    get_ptr(0, p);
    chk("R9 pointer 0 untouched", p, 12'h010);
    get_ptr(1, p);
    chk("R9 pointer 1 stepped", p, 12'h022);
    get_ptr(2, p);
    chk("R9 pointer 2 untouched", p, 12'h030);
  endtask

  task automatic t_self;
    logic [7:0]  d;
    logic [11:0] p;
    set_ptr(2, ra(2, 1));
    rd(ra(2, 1), d);
    chk("R10 self read data", d, 0);
    chk("R10 self read no mem_rd", s_mrd, 0);
    get_ptr(2, p);
    chk("R10 self update happens", p, ra(2, 2));
    set_ptr(0, 12'h555);
    set_ptr(1, ra(0, 0));
    wr(ra(1, 0), 8'h77);
    chk("R10 self write no mem_wr", s_mwr, 0);
    get_ptr(0, p);
    chk("R10 other pointer untouched", p, 12'h555);
    set_ptr(1, ra(1, 0));
    wr(ra(1, 2), 8'h77);
    chk("R10 postdec self no mem_wr", s_mwr, 0);
    get_ptr(1, p);
    chk("R10 postdec self update", p, ra(1, 0) - 12'd1);
    set_ptr(0, 12'hFD0);
    wreg = 8'h10;
    rd(ra(0, 4), d);
    chk("R10 offset into window quiet", s_mrd, 0);
    chk("R10 offset into window data", d, 0);
    wreg = 8'h00;
  endtask

  task automatic t_outside;
    logic [7:0]  d;
    logic [11:0] p;
    set_ptr(0, 12'h050);
    wr(12'h050, 8'hEE);
    chk("R11 outside no mem_wr", s_mwr, 0);
    rd(12'h050, d);
    chk("R11 outside read zero", d, 0);
    chk("R11 outside no mem_rd", s_mrd, 0);
    wr(ra(0, 7), 8'h33);
    chk("R11 spare no mem_wr", s_mwr, 0);
    rd(ra(0, 7), d);
    chk("R11 spare read zero", d, 0);
    get_ptr(0, p);
    chk("R11 pointer unchanged", p, 12'h050);
    rd(ra(0, 0), d);
    chk("R11 memory unchanged", d, pat(12'h050));
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = pat(12'(i));
    cpu_addr = '0; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_wdata = '0; wreg = '0;
    s_mrd = 1'b0; s_mwr = 1'b0; s_maddr = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_plain();
    t_postinc();
    t_postdec();
    t_preinc();
    t_plusw();
    t_indep();
    t_self();
    t_outside();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule